// File: doc/BRIEF.md
# Monochrome Framebuffer Byte Packer

This block turns a 16-bit-per-pixel framebuffer into the byte stream that a small monochrome LCD takes in vertical addressing mode. The default panel is 84 pixels wide and 48 pixels tall. The block reads pixels one at a time over a synchronous read port and reduces each pixel to one bit: a value of zero gives a dark pixel and any other value gives a lit pixel. It packs eight pixels from one column into a byte, so that each byte covers an 8-row strip of that column.

The bytes leave over a valid/ready byte port. The row group advances after each byte, and the column advances after the last row group. A one-cycle start pulse begins a full-frame conversion. A one-cycle done pulse reports that the frame's last byte has been taken. The serial link to the panel and the panel's command sequence are handled by neighbouring logic.

Top module: `mono_packer`

## Requirements
- R1: After reset, byte_valid, done and rd_en are all low, and no bytes appear until start is pulsed.
- R2: A pixel of value 0 gives a 0 bit and any nonzero 16-bit value gives a 1 bit. An all-zero frame yields only 0x00 bytes and an all-0xFFFF frame yields only 0xFF bytes.
- R3: Bit r (0..7) of a byte for row group g holds the pixel at row g*8+r. Bit 0 is the top pixel of the strip.
- R4: A frame is WIDTH*HEIGHT/8 bytes (504 by default). Byte k holds column k/(HEIGHT/8) and row group k%(HEIGHT/8).
- R5: The pixel read address is y*WIDTH+x and always stays below WIDTH*HEIGHT. rd_data is taken one cycle after rd_en with its address.
- R6: While byte_valid is high and byte_ready is low, byte_valid stays high and byte_data stays unchanged in the next cycle.
- R7: rd_en is low in any cycle where byte_valid is high and byte_ready is low.
- R8: done is high for exactly one cycle, in the cycle after the frame's last byte is accepted, and at no other time.
- R9: A start pulse during a conversion is ignored. The frame still yields exactly one set of bytes and one done pulse, and no further bytes follow it.
- R10: A start pulse after done begins a fresh frame from column 0, row group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle pulse that begins a frame conversion when the block is idle |
| rd_en | output | 1 | Pixel read request |
| rd_addr | output | 12 | Pixel address y*WIDTH+x |
| rd_data | input | 16 | Pixel value, returned one cycle after the request |
| byte_data | output | 8 | Packed vertical 8-pixel strip, bit 0 at the top |
| byte_valid | output | 1 | byte_data holds a byte |
| byte_ready | input | 1 | The sink takes the byte this cycle |
| done | output | 1 | One-cycle pulse after the last byte of the frame is accepted |

## Verification
The bench builds the block with its default parameters: an 84x48 panel, 16-bit pixels and 8-row strips. With these values every column end, every row-group end and the final byte 504 come up in each frame. The address range stays within the read port's full 12-bit width. Several frames run back to back with byte_ready held high or dropped at random, so stalls occur on all bit positions of the pack pipeline. A diagonal pattern that places a single lit pixel at a known row in each strip makes any bit-order error visible.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
  localparam int DEF_WIDTH  = 84;
  localparam int DEF_HEIGHT = 48;
  localparam int DEF_PIX_W  = 16;
  localparam int DEF_STRIP  = 8;

  typedef struct packed {
    logic vld;
    logic byte_end;
    logic frame_end;
  } ret_flags_t;
endpackage

// File: rtl/mfb_rst_sync.sv
module mfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/mfb_scan.sv
module mfb_scan #(
  parameter int WIDTH  = 84,
  parameter int HEIGHT = 48,
  parameter int STRIP  = 8,
  localparam int GROUPS = HEIGHT / STRIP,
  localparam int XW     = (WIDTH  > 1) ? $clog2(WIDTH)  : 1,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int RW     = (STRIP  > 1) ? $clog2(STRIP)  : 1,
  localparam int AW     = $clog2(WIDTH * HEIGHT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          adv,
  output logic          active,
  output logic [AW-1:0] addr,
  output logic [RW-1:0] bit_idx,
  output logic          byte_end,
  output logic          frame_end
);
  logic [XW-1:0] x_q, x_d;
  logic [GW-1:0] g_q, g_d;
  logic [RW-1:0] r_q, r_d;
  logic          act_q, act_d;
  logic          grp_end, col_end;
  logic [AW-1:0] row_w;

  assign byte_end  = (r_q == RW'(STRIP - 1));
  assign grp_end   = (g_q == GW'(GROUPS - 1));
  assign col_end   = (x_q == XW'(WIDTH - 1));
  assign frame_end = byte_end && grp_end && col_end;

  always_comb begin
    row_w = AW'(g_q) * AW'(STRIP) + AW'(r_q);
    addr  = row_w * AW'(WIDTH) + AW'(x_q);
  end

  always_comb begin
    x_d   = x_q;
    g_d   = g_q;
    r_d   = r_q;
    act_d = act_q;
    if (go) begin
      x_d   = '0;
      g_d   = '0;
      r_d   = '0;
      act_d = 1'b1;
    end else if (adv) begin
      r_d = r_q + RW'(1);
      if (byte_end) begin
        r_d = '0;
        g_d = g_q + GW'(1);
        if (grp_end) begin
          g_d = '0;
          x_d = x_q + XW'(1);
          if (col_end) begin
            x_d   = '0;
            act_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      g_q   <= '0;
      r_q   <= '0;
      act_q <= 1'b0;
    end else if (go || adv) begin
      x_q   <= x_d;
      g_q   <= g_d;
      r_q   <= r_d;
      act_q <= act_d;
    end
  end

  assign active  = act_q;
  assign bit_idx = r_q;
endmodule

// File: rtl/mfb_pack.sv
module mfb_pack #(
  parameter int STRIP = 8,
  parameter int PIX_W = 16,
  localparam int RW   = (STRIP > 1) ? $clog2(STRIP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [RW-1:0]    bit_idx,
  input  logic [PIX_W-1:0] pix,
  output logic [STRIP-1:0] merged
);
  logic [STRIP-1:0] acc_q;

  always_comb begin
    merged = acc_q;
    merged[bit_idx] = |pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= merged;
  end
endmodule

// File: rtl/mfb_out.sv
module mfb_out #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          lin,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] dout,
  output logic          lout,
  output logic          accept
);
  logic valid_d;

  assign accept = valid && ready;

  always_comb begin
    valid_d = valid;
    if (load)        valid_d = 1'b1;
    else if (accept) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      lout <= 1'b0;
    end else if (load) begin
      dout <= din;
      lout <= lin;
    end
  end
endmodule

// File: rtl/mono_packer.sv
module mono_packer
  import mfb_pkg::*;
#(
  parameter int WIDTH  = DEF_WIDTH,
  parameter int HEIGHT = DEF_HEIGHT,
  parameter int PIX_W  = DEF_PIX_W,
  parameter int STRIP  = DEF_STRIP,
  localparam int AW    = $clog2(WIDTH * HEIGHT),
  localparam int RW    = (STRIP > 1) ? $clog2(STRIP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [PIX_W-1:0] rd_data,
  output logic [STRIP-1:0] byte_data,
  output logic             byte_valid,
  input  logic             byte_ready,
  output logic             done
);
  logic             rst_sn;
  logic             busy_q, busy_d;
  logic             done_d;
  logic             go, stall, active;
  logic [RW-1:0]    scan_idx, ret_idx;
  logic             scan_bend, scan_fend;
  ret_flags_t       ret_q, ret_d;
  logic [STRIP-1:0] merged;
  logic             out_last, accept;

  mfb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign go    = start && !busy_q;
  assign stall = byte_valid && !byte_ready;
  assign rd_en = active && !stall;

  mfb_scan #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .STRIP(STRIP)) u_scan (
    .clk(clk), .rst_n(rst_sn), .go(go), .adv(rd_en), .active(active),
    .addr(rd_addr), .bit_idx(scan_idx), .byte_end(scan_bend),
    .frame_end(scan_fend)
  );

  always_comb begin
    ret_d.vld       = rd_en;
    ret_d.byte_end  = rd_en && scan_bend;
    ret_d.frame_end = rd_en && scan_fend;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ret_q   <= '0;
      ret_idx <= '0;
    end else begin
      ret_q <= ret_d;
      if (rd_en) ret_idx <= scan_idx;
    end
  end

  mfb_pack #(.STRIP(STRIP), .PIX_W(PIX_W)) u_pack (
    .clk(clk), .rst_n(rst_sn), .en(ret_q.vld), .bit_idx(ret_idx),
    .pix(rd_data), .merged(merged)
  );

  mfb_out #(.DW(STRIP)) u_out (
    .clk(clk), .rst_n(rst_sn), .load(ret_q.byte_end), .din(merged),
    .lin(ret_q.frame_end), .ready(byte_ready), .valid(byte_valid),
    .dout(byte_data), .lout(out_last), .accept(accept)
  );

  always_comb begin
    busy_d = busy_q;
    if (go)                       busy_d = 1'b1;
    else if (accept && out_last)  busy_d = 1'b0;
    done_d = accept && out_last;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done   <= done_d;
    end
  end
endmodule

// File: rtl/mono_packer_chk.sv
module mono_packer_chk #(
  parameter int WIDTH  = 84,
  parameter int HEIGHT = 48,
  parameter int STRIP  = 8,
  parameter int AW     = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr,
  input logic [STRIP-1:0] byte_data,
  input logic             byte_valid,
  input logic             byte_ready,
  input logic             done,
  input logic             out_last
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data)); // R6

  AST_NO_FETCH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |-> !rd_en); // R7

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (int'(rd_addr) < WIDTH * HEIGHT)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && byte_ready && out_last |=> done); // R8
endmodule

bind mono_packer mono_packer_chk #(
  .WIDTH(WIDTH), .HEIGHT(HEIGHT), .STRIP(STRIP), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
  .done(done), .out_last(out_last)
);

// File: tb/tb_mono_packer.sv
`timescale 1ns/1ps
module tb_mono_packer;
  localparam int W      = 84;
  localparam int H      = 48;
  localparam int G      = 8;
  localparam int GROUPS = H / G;
  localparam int FRAME  = W * GROUPS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_en;
  logic [11:0] rd_addr;
  logic [15:0] rd_data = 16'h0;
  logic [7:0]  byte_data;
  logic        byte_valid;
  logic        byte_ready = 1'b0;
  logic        done;

  int          checks = 0;
  int          errors = 0;
  int          mode = 0;
  int unsigned seed = 0;
  int          ready_pct = 100;
  int          byte_cnt = 0;
  int          done_cnt = 0;
  int          cycles = 0;
  bit          exp_done_next = 0;
  bit          prev_stall = 0;
  logic [7:0]  prev_data = 8'h0;
  string       data_tag = "R2";

  always #4 clk = ~clk;

  mono_packer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .done(done)
  );

  function automatic logic [15:0] pix(int md, int unsigned sd, int a);
    int x, y;
    logic [31:0] h;
    x = a % W;
    y = a / W;
    h = (32'(a) * 32'h9E3779B1) ^ sd;
    h = h ^ (h >> 15);
    case (md)
      0: return 16'h0000;
      1: return 16'hFFFF;
      3: return ((y % G) == (x % G)) ? 16'h8000 : 16'h0000;
      default: begin
        if (h[3:0] < 4'd5) return 16'h0000;
        else if (h[4])     return 16'h0001 << h[8:5];
        else               return h[31:16] | 16'h0001;
      end
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(int md, int unsigned sd, int k);
    logic [7:0] b;
    int x, g;
    x = k / GROUPS;
    g = k % GROUPS;
    for (int r = 0; r < G; r++) b[r] = (pix(md, sd, (g * G + r) * W + x) != 16'h0);
    return b;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rd_en) rd_data <= pix(mode, seed, int'(rd_addr));

  initial forever begin
    @(posedge clk);
    #1 byte_ready = (($urandom % 100) < ready_pct);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done || exp_done_next) check(done == exp_done_next, "R8 done timing", done, exp_done_next);
      if (done) done_cnt++;
      if (rd_en && (int'(rd_addr) >= W * H)) check(0, "R5 address range", rd_addr, W * H - 1);
      if (prev_stall) begin
        check(byte_valid && byte_data == prev_data, "R6 hold", {byte_valid, byte_data}, {1'b1, prev_data});
        prev_stall = 0;
      end
      if (byte_valid && !byte_ready) begin
        check(!rd_en, "R7 fetch stalled", rd_en, 0);
        prev_stall = 1;
        prev_data  = byte_data;
      end
      if (byte_valid && byte_ready) begin
        check(byte_data == exp_byte(mode, seed, byte_cnt), data_tag, byte_data, exp_byte(mode, seed, byte_cnt));
        exp_done_next = (byte_cnt == FRAME - 1);
        byte_cnt++;
      end else exp_done_next = 0;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        check(0, "watchdog", cycles, 190000);
        finish_run();
      end
    end
  end

  task automatic run_frame(int md, int unsigned sd, int pct, string tag, bit restart_mid, string cnt_tag);
    int wait_cyc;
    @(posedge clk);
    #2;
    mode = md; seed = sd; ready_pct = pct; data_tag = tag;
    byte_cnt = 0; done_cnt = 0;
    start = 1'b1;
    @(posedge clk);
    #2 start = 1'b0;
    if (restart_mid) begin
      repeat (300) @(posedge clk);
      #2 start = 1'b1;
      @(posedge clk);
      #2 start = 1'b0;
    end
    wait_cyc = 0;
    while (done_cnt == 0 && wait_cyc < 40000) begin
      @(posedge clk);
      wait_cyc++;
    end
    repeat (20) begin
      @(negedge clk);
      check(!byte_valid, "R9 no bytes after done", byte_valid, 0);
    end
    check(byte_cnt == FRAME, cnt_tag, byte_cnt, FRAME);
    check(done_cnt == 1, "R8 one done per frame", done_cnt, 1);
  endtask

  initial begin
    void'($urandom(32'd1425));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!byte_valid && !done && !rd_en, "R1 reset state", {byte_valid, done, rd_en}, 0);
    repeat (10) @(negedge clk);
    check(!byte_valid && !rd_en, "R1 idle without start", {byte_valid, rd_en}, 0);

    run_frame(0, 0, 100, "R2 zero frame", 0, "R4 byte count");
    run_frame(1, 0, 100, "R2 full frame", 0, "R10 second frame count");
    run_frame(3, 0, 50, "R3 bit order", 0, "R4 byte count stalls");
    run_frame(2, $urandom, 70, "R4 random frame order", 1, "R9 restart ignored count");
    run_frame(2, $urandom, 30, "R4 random frame heavy stall", 0, "R10 fresh frame count");
    run_frame(2, $urandom, 100, "R2 random nonzero test", 1, "R9 second restart ignored");
    finish_run();
  end
endmodule